// File: doc/BRIEF.md
# Serial Port with Byte Queues and Register Access

This block is a memory-mapped asynchronous serial port. A processor reaches it through a small I/O bus with a 2-bit offset, where the strobe pattern gives the access width: `01` is a byte access and `11` is a 16-bit access. Bytes written to the data offset go into a four-entry transmit queue, and a transmitter sends them out on the serial line. A receiver watches the input line and places each good byte into a four-entry receive queue, and reading the data offset takes bytes from that queue. A single level interrupt combines four buffer conditions, and each condition has its own mask bit.

The transmitter has four states. TX_IDLE goes to TX_START when sending is enabled and the queue holds a byte; that byte is taken from the queue at the same moment. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_STOP after the eighth data bit. TX_STOP returns to TX_IDLE after one bit time.

The receiver also has four states. RX_IDLE goes to RX_START on a high-to-low edge of the input while reception is enabled. RX_START goes to RX_DATA if the line is still low half a bit later, and otherwise falls back to RX_IDLE. RX_DATA goes to RX_STOP after eight samples. RX_STOP returns to RX_IDLE, and stores the byte only if the stop sample is high. An output-enable signal follows the transmit enable, so the top level can release the output pin and use it as general I/O.

Top module: `uart_port`

## Requirements
- R1: After reset, reading offset 0 gives 0x0E (both queues empty, transmit space available, no received data), offset 1 gives the reset divider (15), `ser_tx` is 1, `ser_tx_oe` is 0 and `irq` is 0.
- R2: A byte write to offset 0 stores bit 7 (transmit enable), bit 6 (receive enable) and bits 3:0 (interrupt masks). A read of offset 0 returns bits 7:6 as written and bits 5:4 as 0.
- R3: A 16-bit write to offset 1 sets the divider D, which reads back unchanged. One bit time is D+1 clock cycles.
- R4: Each frame is one low start bit, eight data bits sent LSB first, and one high stop bit. Each of the ten bits lasts D+1 cycles, and the line is high between frames. The next queued byte starts one cycle after the previous stop bit ends.
- R5: A byte write to offset 2 pushes a byte into the transmit queue, which holds 4 bytes. A push while the queue is full is ignored, and that byte is never sent.
- R6: `ser_tx_oe` equals control bit 7. When bit 7 is cleared, a frame already in progress completes, and the remaining queued bytes are held until bit 7 is set again.
- R7: With receive enable set, a frame is detected on a high-to-low edge and the start bit is checked again half a bit later. Each data bit is sampled at its centre, and bytes are read back from offset 2 in arrival order. A low pulse shorter than half a bit stores nothing.
- R8: A frame whose stop sample is low is discarded. A new start is armed only after the line has returned high.
- R9: A byte that arrives while the receive queue holds 4 bytes is dropped. A read of offset 2 while the queue is empty returns the last byte read and leaves the queue unchanged.
- R10: Offset 0 bits 3:0 are live status: bit 3 = transmit queue empty, bit 2 = receive queue empty, bit 1 = transmit queue not full, bit 0 = receive queue not empty.
- R11: `irq` is the OR over i of (mask bit i AND status bit i). It is a level signal that follows the queue state.
- R12: With receive enable clear, frames on `ser_rx` store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_wr_en | input | 2 | Write strobes: 01 byte, 11 16-bit |
| bus_rd_en | input | 2 | Read strobes: 01 byte, 11 16-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset |
| irq | output | 1 | Level interrupt request |
| ser_tx | output | 1 | Serial output line |
| ser_tx_oe | output | 1 | Output-enable for the serial pin |
| ser_rx | input | 1 | Serial input line |

## Verification
The hardest case to reach is a frame cut off by clearing transmit enable. The bench writes the control byte while its model says a frame is part-way out, then checks the line cycle by cycle to confirm the frame completes and that the queue still holds the rest. On the receive side, a bad stop bit is followed by a line held low, so the edge-armed start logic is tested. A fifth frame arrives against a full receive queue, and a read is made from an empty queue. Both of these are reached by driving the serial input from bench tasks at the programmed bit time.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_BAUD = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] STB_BYTE = 2'b01;
    localparam logic [1:0] STB_WORD = 2'b11;
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_push_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [DIV_W-1:0] div,
    input  logic             have_data,
    input  logic [7:0]       din,
    output logic             pop,
    output logic             line
);
    tx_state_t        state_q, state_d;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shifter;
    logic             tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (tx_en && have_data)     state_d = TX_START;
            TX_START: if (tick)                   state_d = TX_DATA;
            TX_DATA:  if (tick && bit_idx == 3'd7) state_d = TX_STOP;
            TX_STOP:  if (tick)                   state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shifter <= '0;
        end else if (state_q == TX_IDLE) begin
            if (pop) begin
                cnt     <= div;
                shifter <= din;
                bit_idx <= '0;
            end
        end else if (tick) begin
            cnt <= div;
            if (state_q == TX_DATA) begin
                shifter <= {1'b0, shifter[7:1]};
                bit_idx <= bit_idx + 3'd1;
            end
        end else begin
            cnt <= cnt - DIV_W'(1);
        end
    end

    always_comb begin
        pop  = (state_q == TX_IDLE) && tx_en && have_data;
        line = 1'b1;
        unique case (state_q)
            TX_START: line = 1'b0;
            TX_DATA:  line = shifter[0];
            default:  line = 1'b1;
        endcase
    end

    assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && !tx_en) |=> (state_q == TX_IDLE));
    assert_idle_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |=> (state_q == TX_IDLE || state_q == TX_START));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [DIV_W-1:0] div,
    input  logic             rx_pin,
    output logic             push,
    output logic [7:0]       dout
);
    rx_state_t        state_q, state_d;
    logic [2:0]       sync;
    logic             rx_s, rx_prev, tick;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shifter;

    assign rx_s    = sync[1];
    assign rx_prev = sync[2];
    assign tick    = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= '1;
        else        sync <= {sync[1:0], rx_pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (rx_en && !rx_s && rx_prev) state_d = RX_START;
            RX_START: if (tick) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && bit_idx == 3'd7)    state_d = RX_STOP;
            RX_STOP:  if (tick)                       state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shifter <= '0;
        end else if (state_q == RX_IDLE) begin
            cnt     <= div >> 1;
            bit_idx <= '0;
        end else if (tick) begin
            cnt <= div;
            if (state_q == RX_DATA) begin
                shifter <= {rx_s, shifter[7:1]};
                bit_idx <= bit_idx + 3'd1;
            end
        end else begin
            cnt <= cnt - DIV_W'(1);
        end
    end

    always_comb begin
        push = (state_q == RX_STOP) && tick && rx_s;
        dout = shifter;
    end

    assert_rx_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && !rx_en) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/uart_port.sv
module uart_port
    import sp_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int RESET_DIV  = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_wr_en,
    input  logic [1:0]  bus_rd_en,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        ser_tx,
    output logic        ser_tx_oe,
    input  logic        ser_rx
);
    logic             tx_en_q, rx_en_q;
    logic [3:0]       irq_mask_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       last_byte;
    logic             wr_byte, wr_word, rd_byte;
    logic             tx_push, tx_pop, tx_empty, tx_full;
    logic             rx_push, rx_pop, rx_empty, rx_full;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [3:0]       status;

    assign wr_byte = (bus_wr_en == STB_BYTE);
    assign wr_word = (bus_wr_en == STB_WORD);
    assign rd_byte = (bus_rd_en == STB_BYTE);
    assign tx_push = wr_byte && (bus_addr == OFS_DATA);
    assign rx_pop  = rd_byte && (bus_addr == OFS_DATA) && !rx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q    <= 1'b0;
            rx_en_q    <= 1'b0;
            irq_mask_q <= '0;
            div_q      <= DIV_W'(RESET_DIV);
            last_byte  <= '0;
        end else begin
            if (wr_byte && bus_addr == OFS_CTRL) begin
                tx_en_q    <= bus_wdata[7];
                rx_en_q    <= bus_wdata[6];
                irq_mask_q <= bus_wdata[3:0];
            end
            if (wr_word && bus_addr == OFS_BAUD) div_q <= bus_wdata[DIV_W-1:0];
            if (rx_pop) last_byte <= rx_head;
        end
    end

    sp_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .wdata(bus_wdata[7:0]), .head(tx_head), .empty(tx_empty), .full(tx_full));

    sp_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .wdata(rx_byte), .head(rx_head), .empty(rx_empty), .full(rx_full));

    sp_tx #(.DIV_W(DIV_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en_q), .div(div_q),
        .have_data(!tx_empty), .din(tx_head), .pop(tx_pop), .line(ser_tx));

    sp_rx #(.DIV_W(DIV_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en_q), .div(div_q),
        .rx_pin(ser_rx), .push(rx_push), .dout(rx_byte));

    assign status    = {tx_empty, rx_empty, !tx_full, !rx_empty};
    assign irq       = |(irq_mask_q & status);
    assign ser_tx_oe = tx_en_q;

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {8'h00, tx_en_q, rx_en_q, 2'b00, status};
            OFS_BAUD: bus_rdata = 16'(div_q);
            OFS_DATA: bus_rdata = {8'h00, rx_empty ? last_byte : rx_head};
            default:  bus_rdata = 16'h0000;
        endcase
    end

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte && bus_addr == OFS_DATA && rx_empty) |=> $stable(last_byte));
    assert_full_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop) |=> rx_full);
endmodule

// File: tb/uart_port_tb_top.sv
`timescale 1ns/1ps
module uart_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [1:0]  bus_wr_en = 2'b00;
    logic [1:0]  bus_rd_en = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq, ser_tx, ser_tx_oe;
    logic        ser_rx = 1'b1;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ser_tx(ser_tx), .ser_tx_oe(ser_tx_oe), .ser_rx(ser_rx));

    // Behavioural reference for the transmit side and control state
    logic [7:0] tx_q [$];
    int         busy = 0;
    int         frame_div = 0;
    logic [7:0] cur = 8'h00;
    bit         tx_en_m = 0, rx_en_m = 0;
    logic [3:0] mask_m = 4'h0;
    int         div_m = 15;

    always @(posedge clk) begin
        if (!rst_n) begin
            tx_q.delete(); busy = 0; tx_en_m = 0; rx_en_m = 0; mask_m = 4'h0; div_m = 15;
        end else begin
            bit full_pre, pop_now;
            full_pre = (tx_q.size() >= 4);
            pop_now  = (busy == 0) && tx_en_m && (tx_q.size() > 0);
            if (busy > 0) busy--;
            if (pop_now) begin
                cur = tx_q.pop_front();
                frame_div = div_m;
                busy = 10 * (div_m + 1);
            end
            if (bus_wr_en == 2'b01 && bus_addr == 2'd2 && !full_pre) tx_q.push_back(bus_wdata[7:0]);
            if (bus_wr_en == 2'b01 && bus_addr == 2'd0) begin
                tx_en_m = bus_wdata[7]; rx_en_m = bus_wdata[6]; mask_m = bus_wdata[3:0];
            end
            if (bus_wr_en == 2'b11 && bus_addr == 2'd1) div_m = int'(bus_wdata);
        end
    end

    function automatic logic model_line();
        int e, idx;
        if (busy == 0) return 1'b1;
        e = 10 * (frame_div + 1) - busy;
        idx = e / (frame_div + 1);
        if (idx == 0) return 1'b0;
        if (idx <= 8) return cur[idx-1];
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic exp_irq;
            chk(ser_tx === model_line(), "R4 serial line", ser_tx, model_line());
            chk(ser_tx_oe === tx_en_m, "R6 output enable", ser_tx_oe, tx_en_m);
            if (bus_addr == 2'd0) begin
                chk(bus_rdata[7:4] === {tx_en_m, rx_en_m, 2'b00}, "R2 control readback",
                    bus_rdata[7:4], {tx_en_m, rx_en_m, 2'b00});
                chk(bus_rdata[3] === (tx_q.size() == 0) && bus_rdata[1] === (tx_q.size() < 4),
                    "R10 transmit status", {bus_rdata[3], bus_rdata[1]},
                    {tx_q.size() == 0, tx_q.size() < 4});
                exp_irq = |(mask_m & {tx_q.size() == 0, bus_rdata[2], tx_q.size() < 4, bus_rdata[0]});
                chk(irq === exp_irq, "R11 interrupt level", irq, exp_irq);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [1:0] stb, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wr_en = stb; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr_en = 2'b00; bus_addr = 2'd0;
    endtask

    task automatic rd_data(output logic [7:0] v);
        @(posedge clk); #1;
        bus_addr = 2'd2; bus_rd_en = 2'b01;
        #1 v = bus_rdata[7:0];
        @(posedge clk); #1;
        bus_rd_en = 2'b00; bus_addr = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive_bit(input logic b);
        @(posedge clk); #1;
        ser_rx = b;
        repeat (div_m) @(posedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(stop);
        @(posedge clk); #1;
        ser_rx = 1'b1;
        idle(2 * (div_m + 1));
    endtask

    task automatic wait_tx_drain();
        while (tx_q.size() != 0 || busy != 0) @(posedge clk);
        idle(3);
    endtask

    initial begin
        logic [7:0] v;
        idle(5);
        rst_n = 1'b1;
        #1;
        // R1 reset values
        chk(bus_rdata === 16'h000E, "R1 reset status", bus_rdata, 16'h000E);
        chk(ser_tx === 1'b1 && ser_tx_oe === 1'b0 && irq === 1'b0, "R1 reset outputs",
            {ser_tx, ser_tx_oe, irq}, 3'b100);
        bus_addr = 2'd1; #0.5;
        chk(bus_rdata === 16'd15, "R1 reset divider", bus_rdata, 16'd15);
        bus_addr = 2'd0;

        // R3 divider write and readback
        wr(2'd1, 2'b11, 16'd2);
        bus_addr = 2'd1; #0.5;
        chk(bus_rdata === 16'd2, "R3 divider readback", bus_rdata, 16'd2);
        bus_addr = 2'd0;

        // R2 control readback with reserved bits written as 1
        wr(2'd0, 2'b01, 16'h00F0);
        #0.5;
        chk(bus_rdata[7:4] === 4'hC, "R2 reserved bits read zero", bus_rdata[7:4], 4'hC);
        wr(2'd0, 2'b01, 16'h0008);
        #0.5;
        chk(irq === 1'b1, "R11 empty mask raises irq", irq, 1'b1);

        // R5 fill transmit queue while sending is disabled, fifth write ignored
        wr(2'd2, 2'b01, 16'h00A5);
        wr(2'd2, 2'b01, 16'h0031);
        wr(2'd2, 2'b01, 16'h00FF);
        wr(2'd2, 2'b01, 16'h0000);
        wr(2'd2, 2'b01, 16'h005C);
        #0.5;
        chk(bus_rdata[1] === 1'b0, "R5 queue full after four", bus_rdata[1], 1'b0);
        wr(2'd0, 2'b01, 16'h0082);
        #0.5;
        chk(irq === 1'b0, "R11 space mask low while full", irq, 1'b0);
        wait_tx_drain();
        chk(bus_rdata[3] === 1'b1, "R5 only four bytes sent", bus_rdata[3], 1'b1);

        // R6 clear enable in mid-frame
        wr(2'd0, 2'b01, 16'h0000);
        wr(2'd2, 2'b01, 16'h0096);
        wr(2'd2, 2'b01, 16'h0069);
        wr(2'd2, 2'b01, 16'h0011);
        wr(2'd0, 2'b01, 16'h0080);
        idle(12);
        wr(2'd0, 2'b01, 16'h0000);
        idle(60);
        chk(bus_rdata[3] === 1'b0 && ser_tx === 1'b1, "R6 held after frame",
            {bus_rdata[3], ser_tx}, 2'b01);
        wr(2'd0, 2'b01, 16'h0080);
        wait_tx_drain();

        // R7 receive path with slower bit time
        wr(2'd1, 2'b11, 16'd7);
        wr(2'd0, 2'b01, 16'h0041);
        send_rx(8'hA5, 1'b1);
        send_rx(8'h3C, 1'b1);
        #0.5;
        chk(bus_rdata[0] === 1'b1 && bus_rdata[2] === 1'b0, "R10 receive status",
            {bus_rdata[2], bus_rdata[0]}, 2'b01);
        rd_data(v); chk(v === 8'hA5, "R7 first byte", v, 8'hA5);
        rd_data(v); chk(v === 8'h3C, "R7 second byte", v, 8'h3C);
        rd_data(v); chk(v === 8'h3C, "R9 empty read repeats last", v, 8'h3C);
        #0.5;
        chk(bus_rdata[2] === 1'b1, "R9 empty read keeps queue empty", bus_rdata[2], 1'b1);

        // R7 short glitch
        @(posedge clk); #1; ser_rx = 1'b0;
        @(posedge clk); #1; ser_rx = 1'b1;
        idle(100);
        chk(bus_rdata[2] === 1'b1, "R7 glitch ignored", bus_rdata[2], 1'b1);

        // R8 low stop bit, line held low, then good frame
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(1'b1);
        drive_bit(1'b0);
        idle(40);
        @(posedge clk); #1; ser_rx = 1'b1;
        idle(20);
        #0.5;
        chk(bus_rdata[2] === 1'b1, "R8 bad frame discarded", bus_rdata[2], 1'b1);
        send_rx(8'h5A, 1'b1);
        rd_data(v); chk(v === 8'h5A, "R8 next good frame", v, 8'h5A);

        // R9 overflow of receive queue
        for (int i = 1; i <= 5; i++) send_rx(8'(i), 1'b1);
        for (int i = 1; i <= 4; i++) begin
            rd_data(v); chk(v === 8'(i), "R9 queued byte order", v, 8'(i));
        end
        #0.5;
        chk(bus_rdata[2] === 1'b1, "R9 fifth byte dropped", bus_rdata[2], 1'b1);

        // R12 receiver disabled
        wr(2'd0, 2'b01, 16'h0001);
        send_rx(8'h77, 1'b1);
        #0.5;
        chk(bus_rdata[2] === 1'b1 && irq === 1'b0, "R12 disabled receiver stores nothing",
            {bus_rdata[2], irq}, 2'b10);

        idle(5);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule